// File: doc/BRIEF.md
# Capture/Compare Timer with Edge-Triggered Restart

This block is a free-running up-counter that advances once per cycle in which the count-enable tick is high. It has two data registers, A and B, and two external trigger pins, P and Q. Each register works either as a compare register or as a capture register. As a compare register it raises its own one-cycle interrupt pulse when its value equals the count, and the count keeps running. As a capture register it copies the count when its trigger fires. The trigger for B is always pin P. The trigger for A is either P or Q, chosen by a control bit.

Both pins are asynchronous. Each passes through a synchronizer and then an edge detector with a 2-bit edge-select field. When the restart mode is on, a valid edge on P sets the count back to zero, and counting goes on from zero on later ticks. The same edge can capture into B in that cycle, and B then holds the count from before the clear.

Software reaches the block through a plain synchronous register port. A write takes effect on the clock edge where `wr_en` is high. `rdata` is a registered copy of the register selected by `addr`, so it follows one cycle after `addr`. The port has no handshake and no back-pressure: every access completes in one cycle.

Register addresses: 0 is control, 1 is A, 2 is B, 3 is the count (read-only).

Control register bits:
- Bit 0: restart enable.
- Bit 1: A in capture mode.
- Bit 2: B in capture mode.
- Bit 3: A triggered by Q. When this bit is 0, A is triggered by P.
- Bits 5:4: P edge-select field.
- Bits 7:6: Q edge-select field.

Top module: `cc_timer`

## Requirements
- R1: After a synchronous reset the count, A, B and the control register read as zero and both interrupts are low. A compare match that already holds when reset is released does not pulse.
- R2: The count increments by one on each clock edge where `tick` is high and holds otherwise. It wraps from 0xFFFF to 0x0000.
- R3: Edge-select codes work as follows: 2'b00 selects falling edges, 2'b01 rising edges and 2'b11 both edges. The prohibited code 2'b10 never reports an edge, so it never causes a capture or a restart.
- R4: With restart enable (bit 0) set, a valid P edge clears the count to zero, and the clear wins over `tick`. With bit 0 clear, P edges leave the count alone.
- R5: In compare mode a register pulses its interrupt for exactly one cycle, one cycle after the count first equals its value, and the count is not cleared. A register in capture mode raises no interrupt.
- R6: In capture mode, A copies the count on a valid edge of Q when bit 3 is 1, or of P when bit 3 is 0.
- R7: In capture mode, B copies the count on a valid P edge.
- R8: When A captures from Q (bits 1 and 3 set) and Q's edge-select is 2'b11, that combination is invalid and edges on Q are ignored.
- R9: When a capture and a restart clear fall in the same cycle, the captured value is the count before the clear.
- R10: Reading any address returns that register one cycle later. Reading address 3 returns the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable |
| trig_p | input | 1 | Trigger pin P (asynchronous) |
| trig_q | input | 1 | Trigger pin Q (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq_a | output | 1 | Compare interrupt for A |
| irq_b | output | 1 | Compare interrupt for B |

## Verification
The assertions assume that `tick`, `wr_en`, `addr` and `wdata` are clean synchronous levels with no unknowns once reset is released. The trigger pins may change at any time, because only their synchronized copies reach the checked logic. The stimulus drives every input at the falling clock edge. It changes a trigger pin only while `tick` is low, and holds the pin for four cycles so the synchronizer settles before any result is read. It changes the control register only while the pins are steady, so a new edge-select value never sees a false edge.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    edge_sel_e q_edge;
    edge_sel_e p_edge;
    logic      a_from_q;
    logic      b_cap;
    logic      a_cap;
    logic      restart_en;
  } ctrl_t;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_A     = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_B     = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_COUNT = 2'd3;
endpackage

// File: rtl/cc_edge_det.sv
module cc_edge_det
  import cc_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      din,
  input  edge_sel_e sel,
  input  logic      en,
  output logic      hit
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] shreg;
  logic          cur, prev, rise, fall;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[LAST-1:0], din};
  end

  assign cur  = shreg[LAST-1];
  assign prev = shreg[LAST];
  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  always_comb begin
    unique case (sel)
      EDGE_FALL: hit = en & fall;
      EDGE_RISE: hit = en & rise;
      EDGE_BOTH: hit = en & (rise | fall);
      default:   hit = 1'b0;
    endcase
  end

  p_prohib_r3: assert property (@(posedge clk) disable iff (rst)
    (sel == EDGE_NONE) |-> !hit);
  p_stable_pin_r3: assert property (@(posedge clk) disable iff (rst)
    (cur == prev) |-> !hit);
endmodule

// File: rtl/cc_chan.sv
module cc_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             cap_mode,
  input  logic             cap_evt,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] val,
  output logic             irq
);
  logic match, match_d;

  always_ff @(posedge clk) begin
    if (rst)                       val <= '0;
    else if (cap_mode && cap_evt)  val <= cnt;
    else if (wr)                   val <= wdata;
  end

  assign match = !cap_mode && (val == cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_d <= 1'b1;
      irq     <= 1'b0;
    end else begin
      match_d <= match;
      irq     <= match & ~match_d;
    end
  end

  p_capture_r6: assert property (@(posedge clk) disable iff (rst)
    (cap_mode && cap_evt) |=> (val == $past(cnt)));
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  p_noirq_cap_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(cap_mode) && cap_mode) |-> !irq);
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              trig_p,
  input  logic              trig_q,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq_a,
  output logic              irq_b
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt, val_a, val_b;
  logic             p_ev, q_ev, q_allow, clr, a_trig;

  always_ff @(posedge clk) begin
    if (rst)                            ctrl <= '0;
    else if (wr_en && addr == ADR_CTRL) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  assign q_allow = !(ctrl.a_cap && ctrl.a_from_q && ctrl.q_edge == EDGE_BOTH);

  cc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_p_det (
    .clk(clk), .rst(rst), .din(trig_p), .sel(ctrl.p_edge), .en(1'b1), .hit(p_ev));
  cc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_q_det (
    .clk(clk), .rst(rst), .din(trig_q), .sel(ctrl.q_edge), .en(q_allow), .hit(q_ev));

  assign clr    = ctrl.restart_en & p_ev;
  assign a_trig = ctrl.a_from_q ? q_ev : p_ev;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  cc_chan #(.CNT_W(CNT_W)) u_chan_a (
    .clk(clk), .rst(rst), .wr(wr_en && addr == ADR_A), .wdata(wdata),
    .cap_mode(ctrl.a_cap), .cap_evt(a_trig), .cnt(cnt), .val(val_a), .irq(irq_a));
  cc_chan #(.CNT_W(CNT_W)) u_chan_b (
    .clk(clk), .rst(rst), .wr(wr_en && addr == ADR_B), .wdata(wdata),
    .cap_mode(ctrl.b_cap), .cap_evt(p_ev), .cnt(cnt), .val(val_b), .irq(irq_b));

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      unique case (addr)
        ADR_CTRL: rdata <= CNT_W'(ctrl);
        ADR_A:    rdata <= val_a;
        ADR_B:    rdata <= val_b;
        default:  rdata <= cnt;
      endcase
    end
  end

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  p_count_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt));
  p_q_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    !q_allow |-> !q_ev);
endmodule

// File: tb/tb_cc_timer.sv
module tb_cc_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, tick, trig_p, trig_q, wr_en;
  logic [1:0]  addr;
  logic [15:0] wdata, rdata, rv;
  logic        irq_a, irq_b;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_timer dut (.clk(clk), .rst(rst), .tick(tick), .trig_p(trig_p), .trig_q(trig_q),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_p(logic v);
    @(negedge clk); trig_p = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_q(logic v);
    @(negedge clk); trig_q = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq_a", 16'(irq_a), 16'h0);
    chk("R1 irq_b", 16'(irq_b), 16'h0);
    rd(2'd0, rv); chk("R1 ctrl", rv, 16'h0);
    rd(2'd1, rv); chk("R1 A", rv, 16'h0);
    rd(2'd2, rv); chk("R1 B", rv, 16'h0);
    rd(2'd3, rv); chk("R1/R10 count", rv, 16'h0);
    chk("R1 no pulse on held match", 16'(irq_a | irq_b), 16'h0);
  endtask

  task automatic t_count;
    ticks(5);
    rd(2'd3, rv); chk("R2 count after 5 ticks", rv, 16'd5);
    repeat (3) @(negedge clk);
    rd(2'd3, rv); chk("R2 hold without tick", rv, 16'd5);
  endtask

  task automatic t_compare;
    int na = 0, nb = 0, ia = 0, ib = 0;
    wr(2'd1, 16'd7);
    wr(2'd2, 16'd9);
    @(negedge clk); tick = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (irq_a) begin na++; ia = i; end
      if (irq_b) begin nb++; ib = i; end
    end
    tick = 1'b0;
    chk("R5 irq_a pulse count", 16'(na), 16'd1);
    chk("R5 irq_a timing", 16'(ia), 16'd3);
    chk("R5 irq_b pulse count", 16'(nb), 16'd1);
    chk("R5 irq_b timing", 16'(ib), 16'd5);
    rd(2'd3, rv); chk("R5 count not cleared", rv, 16'd11);
  endtask

  task automatic t_restart_edges;
    wr(2'd0, 16'h0011);
    rd(2'd0, rv); chk("R10 ctrl readback", rv, 16'h0011);
    set_p(1'b1); rd(2'd3, rv); chk("R4 rise clears", rv, 16'd0);
    ticks(3);   rd(2'd3, rv); chk("R4 counting restarts", rv, 16'd3);
    set_p(1'b0); rd(2'd3, rv); chk("R3 rise-select ignores fall", rv, 16'd3);
    wr(2'd0, 16'h0001);
    set_p(1'b1); rd(2'd3, rv); chk("R3 fall-select ignores rise", rv, 16'd3);
    set_p(1'b0); rd(2'd3, rv); chk("R3 fall-select clears", rv, 16'd0);
    wr(2'd0, 16'h0031);
    ticks(2); set_p(1'b1); rd(2'd3, rv); chk("R3 both: rise clears", rv, 16'd0);
    ticks(2); set_p(1'b0); rd(2'd3, rv); chk("R3 both: fall clears", rv, 16'd0);
    wr(2'd0, 16'h0021);
    ticks(3); set_p(1'b1); set_p(1'b0);
    rd(2'd3, rv); chk("R3 code 10 no edge", rv, 16'd3);
    wr(2'd0, 16'h0010);
    set_p(1'b1); set_p(1'b0);
    rd(2'd3, rv); chk("R4 restart disabled", rv, 16'd3);
  endtask

  task automatic t_capture_b;
    wr(2'd0, 16'h0015);
    ticks(4);
    set_p(1'b1);
    rd(2'd2, rv); chk("R7/R9 B holds pre-clear count", rv, 16'd7);
    rd(2'd3, rv); chk("R9 count cleared same edge", rv, 16'd0);
    set_p(1'b0);
  endtask

  task automatic t_capture_a;
    wr(2'd0, 16'h004A);
    ticks(5);
    set_q(1'b1);
    rd(2'd1, rv); chk("R6 A captures on Q", rv, 16'd5);
    rd(2'd3, rv); chk("R6 count unchanged", rv, 16'd5);
    wr(2'd0, 16'h0012);
    ticks(2);
    set_p(1'b1);
    rd(2'd1, rv); chk("R6 A captures on P", rv, 16'd7);
    set_p(1'b0);
    set_q(1'b0);
  endtask

  task automatic t_invalid_q;
    wr(2'd0, 16'h00CA);
    ticks(3);
    set_q(1'b1); rd(2'd1, rv); chk("R8 Q rise ignored", rv, 16'd7);
    set_q(1'b0); rd(2'd1, rv); chk("R8 Q fall ignored", rv, 16'd7);
    wr(2'd0, 16'h004A);
    set_q(1'b1); rd(2'd1, rv); chk("R8 valid setting captures", rv, 16'd10);
    set_q(1'b0);
  endtask

  task automatic t_wrap;
    wr(2'd0, 16'h0011);
    set_p(1'b1); set_p(1'b0);
    wr(2'd0, 16'h0000);
    ticks(65535);
    rd(2'd3, rv); chk("R2 reaches max", rv, 16'hFFFF);
    ticks(1);
    rd(2'd3, rv); chk("R2 wraps to zero", rv, 16'h0000);
  endtask

  initial begin
    rst = 1'b1; tick = 1'b0; trig_p = 1'b0; trig_q = 1'b0;
    wr_en = 1'b0; addr = 2'd0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count();
    t_compare();
    t_restart_edges();
    t_capture_b();
    t_capture_a();
    t_invalid_q();
    t_wrap();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule